// File: doc/BRIEF.md
# Integer ADD Instruction Decoder

This block takes a window of up to fifteen instruction bytes from the fetch path of a core running in 64-bit mode. It decides whether the bytes hold one of the integer ADD forms with register operands. If they do, it reports the operand width, the destination and source registers, whether the source is an immediate (and its value, already extended to the operand width), and how many bytes the instruction occupies. The result is registered, so it appears one clock after the bytes are presented with `in_valid` high.

The scanner accepts up to `MAX_PFX` legacy prefixes at the start of the window. Only two prefixes are recognised: the operand-size override (66h) and the bus-lock prefix (F0h). They may appear in any order. A byte from 40h to 4Fh that sits directly before the opcode is taken as the register-extension prefix, with these bits:

- bit 3 widens the operation to 64 bits;
- bit 2 extends the ModRM reg field;
- bit 0 extends the ModRM r/m field.

Only ModRM forms with mod = 11b are decoded. Anything else is reported as not valid. A bus-lock prefix on any recognised form raises the invalid-opcode fault, because every destination here is a register.

Byte 0 of the window is bits 7:0 of `in_bytes`, and later bytes follow at higher bits.

Top module: `add_insn_decoder`

## Requirements
- R1: `out_valid` rises exactly one clock after a recognised, unlocked ADD is presented with `in_valid` high. In every cycle whose input had `in_valid` low, all outputs are zero.
- R2: The operand-size code on `out_size` is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Opcodes 00h, 02h, 04h and 80h are always 8-bit. The other forms are 32-bit by default, 16-bit after 66h, and 64-bit when the extension prefix has bit 3 set, even if 66h is also present.
- R3: For opcodes 00h and 01h the destination is the r/m register and the source is the reg register. For 02h and 03h the two are swapped.
- R4: Opcodes 04h and 05h have no ModRM byte. Their destination is register 0 and their source is an immediate, with `out_src` reading 0. 04h carries one immediate byte. 05h carries two bytes at 16-bit size and four bytes otherwise.
- R5: Opcodes 80h, 81h and 83h are ADD only when ModRM bits 5:3 are zero, and the destination is then the r/m register. 80h carries one immediate byte. 81h carries two bytes at 16-bit size and four bytes otherwise. 83h carries one byte.
- R6: The immediate is read little-endian and sign-extended to the operand width. Bits of `out_imm` above the operand width are zero.
- R7: Extension bit 2 sets bit 3 of the register index taken from the reg field. Extension bit 0 sets bit 3 of the index taken from the r/m field.
- R8: At 8-bit size with no extension prefix, a register code of 4 to 7 reports index code−4 with the matching hi flag set (the upper byte of registers 0 to 3). When an extension prefix is present, the full index is reported and the hi flag stays clear.
- R9: A recognised ADD that carries F0h gives `out_fault` = 1 and `out_valid` = 0, with every other output zero.
- R10: `out_len` equals the number of legacy prefixes, plus 1 if the extension prefix is present, plus 1 for the opcode, plus 1 if there is a ModRM byte, plus the number of immediate bytes.
- R11: Any of the following gives `out_valid` = 0 and `out_fault` = 0, even when F0h is present: an opcode outside {00h, 01h, 02h, 03h, 04h, 05h, 80h, 81h, 83h}, a ModRM form with mod ≠ 11b, a group opcode whose reg field is non-zero, or a run of prefixes longer than `MAX_PFX`.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction window is present this cycle |
| in_bytes | input | 120 | Instruction bytes, byte 0 at bits 7:0 |
| out_valid | output | 1 | Register-form ADD decoded without fault |
| out_fault | output | 1 | Invalid-opcode fault (lock on register destination) |
| out_size | output | 2 | Operand size code: 0=8, 1=16, 2=32, 3=64 bits |
| out_dst | output | 4 | Destination register index |
| out_dst_hi | output | 1 | Destination is the upper byte of register 0 to 3 |
| out_src | output | 4 | Source register index (0 when immediate) |
| out_src_hi | output | 1 | Source is the upper byte of register 0 to 3 |
| out_src_imm | output | 1 | Source is the immediate |
| out_imm | output | 64 | Immediate, sign-extended to the operand width |
| out_len | output | 4 | Instruction length in bytes |

## Verification
The decoder keeps no state between instructions, apart from the output register. Any internal fault therefore shows up at the ports on the very next clock, for the instruction that provoked it. A prefix miscount shows up as a wrong length, wrong opcode or wrong immediate. A wrong size selection shows up as stray high bits in the immediate or a wrong size code. A register-mapping slip shows up as a swapped index or a misplaced hi flag. Comparing every output field against a behavioural model on every cycle, over directed corner forms and a long random mix of prefixes and opcodes, catches each of these one cycle after the input that exposes it.

// File: rtl/add_dec_pkg.sv
package add_dec_pkg;

    parameter int unsigned INSN_MAX_BYTES = 15;
    localparam int unsigned BUF_W = INSN_MAX_BYTES * 8;
    localparam int unsigned LEN_W = $clog2(INSN_MAX_BYTES + 1);

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } opsize_e;

    typedef struct packed {
        logic             valid;
        logic             fault;
        opsize_e          size;
        logic [3:0]       dst;
        logic             dst_hi;
        logic [3:0]       src;
        logic             src_hi;
        logic             src_imm;
        logic [63:0]      imm;
        logic [LEN_W-1:0] len;
    } dec_out_t;

    // Returns {hi_flag, index} for a 4-bit register code.
    function automatic logic [4:0] map_gpr(input logic [3:0] enc,
                                           input logic       byte_op,
                                           input logic       rex_seen);
        if (byte_op && !rex_seen && enc[2])
            return {1'b1, 2'b00, enc[1:0]};
        return {1'b0, enc};
    endfunction

endpackage

// File: rtl/add_dec_prefix.sv
module add_dec_prefix
    import add_dec_pkg::*;
#(
    parameter int unsigned MAX_PFX = 4
) (
    input  logic [BUF_W-1:0] buf_i,
    output logic [LEN_W-1:0] opc_pos_o,
    output logic             opsz16_o,
    output logic             lock_o,
    output logic             rex_seen_o,
    output logic             rex_w_o,
    output logic             rex_r_o,
    output logic             rex_b_o
);
    logic [LEN_W-1:0] cnt;
    logic             stop;
    logic [7:0]       after;

    always_comb begin
        cnt      = '0;
        stop     = 1'b0;
        opsz16_o = 1'b0;
        lock_o   = 1'b0;
        for (int i = 0; i < MAX_PFX; i++) begin
            if (!stop) begin
                if (buf_i[i*8 +: 8] == 8'h66) begin
                    opsz16_o = 1'b1;
                    cnt      = cnt + LEN_W'(1);
                end else if (buf_i[i*8 +: 8] == 8'hF0) begin
                    lock_o = 1'b1;
                    cnt    = cnt + LEN_W'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    assign after      = 8'(buf_i >> {cnt, 3'b000});
    assign rex_seen_o = (after[7:4] == 4'h4);
    assign rex_w_o    = rex_seen_o & after[3];
    assign rex_r_o    = rex_seen_o & after[2];
    assign rex_b_o    = rex_seen_o & after[0];
    assign opc_pos_o  = cnt + LEN_W'(rex_seen_o);

endmodule

// File: rtl/add_dec_form.sv
module add_dec_form
    import add_dec_pkg::*;
(
    input  logic [7:0] opcode_i,
    input  logic [1:0] mod_i,
    input  logic [2:0] ext_i,
    input  logic       rex_w_i,
    input  logic       opsz16_i,
    output logic       is_add_o,
    output logic       has_modrm_o,
    output logic       reg_dst_o,
    output logic       uses_imm_o,
    output logic       acc_form_o,
    output logic [2:0] imm_bytes_o,
    output opsize_e    size_o
);
    opsize_e    cur;
    logic [2:0] wide_imm;

    assign cur      = rex_w_i ? SZ64 : (opsz16_i ? SZ16 : SZ32);
    assign wide_imm = (cur == SZ16) ? 3'd2 : 3'd4;

    always_comb begin
        is_add_o    = 1'b1;
        has_modrm_o = 1'b1;
        reg_dst_o   = 1'b0;
        uses_imm_o  = 1'b0;
        acc_form_o  = 1'b0;
        imm_bytes_o = 3'd0;
        size_o      = cur;
        unique case (opcode_i)
            8'h00: size_o = SZ8;
            8'h01: ;
            8'h02: begin size_o = SZ8; reg_dst_o = 1'b1; end
            8'h03: reg_dst_o = 1'b1;
            8'h04: begin
                size_o = SZ8; has_modrm_o = 1'b0; acc_form_o = 1'b1;
                uses_imm_o = 1'b1; imm_bytes_o = 3'd1;
            end
            8'h05: begin
                has_modrm_o = 1'b0; acc_form_o = 1'b1;
                uses_imm_o = 1'b1; imm_bytes_o = wide_imm;
            end
            8'h80: begin
                size_o = SZ8; uses_imm_o = 1'b1; imm_bytes_o = 3'd1;
                is_add_o = (ext_i == 3'd0);
            end
            8'h81: begin
                uses_imm_o = 1'b1; imm_bytes_o = wide_imm;
                is_add_o = (ext_i == 3'd0);
            end
            8'h83: begin
                uses_imm_o = 1'b1; imm_bytes_o = 3'd1;
                is_add_o = (ext_i == 3'd0);
            end
            default: is_add_o = 1'b0;
        endcase
        if (has_modrm_o && mod_i != 2'b11)
            is_add_o = 1'b0;
    end

endmodule

// File: rtl/add_dec_imm.sv
module add_dec_imm
    import add_dec_pkg::*;
(
    input  logic [31:0] raw_i,
    input  logic [2:0]  nbytes_i,
    input  opsize_e     size_i,
    output logic [63:0] value_o
);
    logic [63:0] sx;

    always_comb begin
        case (nbytes_i)
            3'd1:    sx = {{56{raw_i[7]}},  raw_i[7:0]};
            3'd2:    sx = {{48{raw_i[15]}}, raw_i[15:0]};
            3'd4:    sx = {{32{raw_i[31]}}, raw_i};
            default: sx = '0;
        endcase
        unique case (size_i)
            SZ8:  value_o = {56'd0, sx[7:0]};
            SZ16: value_o = {48'd0, sx[15:0]};
            SZ32: value_o = {32'd0, sx[31:0]};
            SZ64: value_o = sx;
        endcase
    end

endmodule

// File: rtl/add_insn_decoder.sv
module add_insn_decoder
    import add_dec_pkg::*;
#(
    parameter int unsigned MAX_PFX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUF_W-1:0] in_bytes,
    output logic             out_valid,
    output logic             out_fault,
    output logic [1:0]       out_size,
    output logic [3:0]       out_dst,
    output logic             out_dst_hi,
    output logic [3:0]       out_src,
    output logic             out_src_hi,
    output logic             out_src_imm,
    output logic [63:0]      out_imm,
    output logic [LEN_W-1:0] out_len
);
    logic [LEN_W-1:0] opc_pos;
    logic             opsz16, lock, rex_seen, rex_w, rex_r, rex_b;
    logic [47:0]      win;
    logic [7:0]       opcode, modrm;
    logic [31:0]      imm_raw;
    logic             is_add, has_modrm, reg_dst, uses_imm, acc_form;
    logic [2:0]       imm_bytes;
    opsize_e          size;
    logic [63:0]      imm_val;
    logic [4:0]       reg_map, rm_map;
    dec_out_t         res_d, res_q;

    add_dec_prefix #(.MAX_PFX(MAX_PFX)) u_prefix (
        .buf_i      (in_bytes),
        .opc_pos_o  (opc_pos),
        .opsz16_o   (opsz16),
        .lock_o     (lock),
        .rex_seen_o (rex_seen),
        .rex_w_o    (rex_w),
        .rex_r_o    (rex_r),
        .rex_b_o    (rex_b)
    );

    assign win     = 48'(in_bytes >> {opc_pos, 3'b000});
    assign opcode  = win[7:0];
    assign modrm   = win[15:8];
    assign imm_raw = has_modrm ? win[47:16] : win[39:8];

    add_dec_form u_form (
        .opcode_i    (opcode),
        .mod_i       (modrm[7:6]),
        .ext_i       (modrm[5:3]),
        .rex_w_i     (rex_w),
        .opsz16_i    (opsz16),
        .is_add_o    (is_add),
        .has_modrm_o (has_modrm),
        .reg_dst_o   (reg_dst),
        .uses_imm_o  (uses_imm),
        .acc_form_o  (acc_form),
        .imm_bytes_o (imm_bytes),
        .size_o      (size)
    );

    add_dec_imm u_imm (
        .raw_i    (imm_raw),
        .nbytes_i (imm_bytes),
        .size_i   (size),
        .value_o  (imm_val)
    );

    assign reg_map = map_gpr({rex_r, modrm[5:3]}, size == SZ8, rex_seen);
    assign rm_map  = map_gpr({rex_b, modrm[2:0]}, size == SZ8, rex_seen);

    always_comb begin
        res_d = '0;
        if (in_valid && is_add) begin
            if (lock) begin
                res_d.fault = 1'b1;
            end else begin
                res_d.valid = 1'b1;
                res_d.size  = size;
                res_d.len   = opc_pos + LEN_W'(1) + LEN_W'(has_modrm)
                            + LEN_W'(imm_bytes);
                if (acc_form) begin
                    res_d.src_imm = 1'b1;
                    res_d.imm     = imm_val;
                end else if (uses_imm) begin
                    {res_d.dst_hi, res_d.dst} = rm_map;
                    res_d.src_imm = 1'b1;
                    res_d.imm     = imm_val;
                end else if (reg_dst) begin
                    {res_d.dst_hi, res_d.dst} = reg_map;
                    {res_d.src_hi, res_d.src} = rm_map;
                end else begin
                    {res_d.dst_hi, res_d.dst} = rm_map;
                    {res_d.src_hi, res_d.src} = reg_map;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign out_fault   = res_q.fault;
    assign out_size    = res_q.size;
    assign out_dst     = res_q.dst;
    assign out_dst_hi  = res_q.dst_hi;
    assign out_src     = res_q.src;
    assign out_src_hi  = res_q.src_hi;
    assign out_src_imm = res_q.src_imm;
    assign out_imm     = res_q.imm;
    assign out_len     = res_q.len;

endmodule

// File: rtl/add_insn_decoder_chk.sv
module add_insn_decoder_chk
    import add_dec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_fault,
    input logic [1:0]       out_size,
    input logic [3:0]       out_src,
    input logic             out_src_hi,
    input logic             out_dst_hi,
    input logic             out_src_imm,
    input logic [63:0]      out_imm,
    input logic [LEN_W-1:0] out_len
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !out_fault && out_len == '0));

    assert_no_dual_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_len == '0 && out_imm == 64'd0 && !out_src_imm));

    assert_imm_src_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_src_imm |-> (out_src == 4'd0 && !out_src_hi));

    assert_hi_byte_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dst_hi || out_src_hi) |-> out_size == 2'd0);

    assert_imm_fit8_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'd0) |-> out_imm[63:8] == '0);

    assert_imm_fit16_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'd1) |-> out_imm[63:16] == '0);

    assert_imm_fit32_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'd2) |-> out_imm[63:32] == '0);

    assert_len_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len >= LEN_W'(2));

endmodule

bind add_insn_decoder add_insn_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_fault   (out_fault),
    .out_size    (out_size),
    .out_src     (out_src),
    .out_src_hi  (out_src_hi),
    .out_dst_hi  (out_dst_hi),
    .out_src_imm (out_src_imm),
    .out_imm     (out_imm),
    .out_len     (out_len)
);

// File: tb/add_insn_decoder_test.sv
`timescale 1ns/1ps
module add_insn_decoder_test;
    localparam int NB = add_dec_pkg::INSN_MAX_BYTES;

    typedef struct {
        bit              v;
        bit              f;
        int              sz;
        int              dst;
        bit              dhi;
        int              src;
        bit              shi;
        bit              simm;
        longint unsigned imm;
        int              len;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NB*8-1:0] in_bytes = '0;
    logic            out_valid, out_fault, out_dst_hi, out_src_hi, out_src_imm;
    logic [1:0]      out_size;
    logic [3:0]      out_dst, out_src, out_len;
    logic [63:0]     out_imm;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [7:0] sq[$];

    always #2.5 clk = ~clk;

    add_insn_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .out_valid(out_valid), .out_fault(out_fault), .out_size(out_size),
        .out_dst(out_dst), .out_dst_hi(out_dst_hi), .out_src(out_src),
        .out_src_hi(out_src_hi), .out_src_imm(out_src_imm),
        .out_imm(out_imm), .out_len(out_len)
    );

    function automatic exp_t model(input bit v, input logic [NB*8-1:0] bb);
        exp_t e;
        int p = 0, sz = 0, nimm = 0, cur, regv, rmv, pos;
        bit o16 = 0, lk = 0, rx = 0, w = 0, r = 0, bx = 0;
        bit mrm = 1, ok = 1, rdst = 0, grp = 0, acc = 0;
        logic [7:0] op, m;
        longint unsigned raw = 0;
        e = '{0, 0, 0, 0, 0, 0, 0, 0, 64'd0, 0};
        if (!v) return e;
        while (p < 4 && (bb[p*8 +: 8] == 8'h66 || bb[p*8 +: 8] == 8'hF0)) begin
            if (bb[p*8 +: 8] == 8'h66) o16 = 1; else lk = 1;
            p++;
        end
        if (bb[p*8+4 +: 4] == 4'h4) begin
            rx = 1; w = bb[p*8+3]; r = bb[p*8+2]; bx = bb[p*8];
            p++;
        end
        op = bb[p*8 +: 8];
        p++;
        m = bb[p*8 +: 8];
        cur = w ? 64 : (o16 ? 16 : 32);
        case (op)
            8'h00: sz = 8;
            8'h01: sz = cur;
            8'h02: begin sz = 8; rdst = 1; end
            8'h03: begin sz = cur; rdst = 1; end
            8'h04: begin sz = 8; mrm = 0; acc = 1; nimm = 1; end
            8'h05: begin sz = cur; mrm = 0; acc = 1; nimm = (cur == 16) ? 2 : 4; end
            8'h80: begin sz = 8; grp = 1; nimm = 1; end
            8'h81: begin sz = cur; grp = 1; nimm = (cur == 16) ? 2 : 4; end
            8'h83: begin sz = cur; grp = 1; nimm = 1; end
            default: ok = 0;
        endcase
        if (grp && m[5:3] != 3'd0) ok = 0;
        if (mrm && m[7:6] != 2'b11) ok = 0;
        if (!ok) return e;
        if (lk) begin e.f = 1; return e; end
        e.v = 1;
        e.sz = (sz == 8) ? 0 : (sz == 16) ? 1 : (sz == 32) ? 2 : 3;
        e.len = p + int'(mrm) + nimm;
        regv = int'(r) * 8 + int'(m[5:3]);
        rmv  = int'(bx) * 8 + int'(m[2:0]);
        pos = p + int'(mrm);
        for (int k = 0; k < nimm; k++)
            raw = raw | (longint'(bb[(pos+k)*8 +: 8]) << (8*k));
        if (nimm > 0 && ((raw >> (8*nimm - 1)) & 1) == 1)
            raw = raw | (~64'd0 << (8*nimm));
        if (sz < 64) raw = raw & ((64'd1 << sz) - 1);
        if (acc) begin
            e.simm = 1; e.imm = raw;
            return e;
        end
        if (grp) begin
            e.dst = rmv; e.simm = 1; e.imm = raw;
        end else if (rdst) begin
            e.dst = regv; e.src = rmv;
        end else begin
            e.dst = rmv; e.src = regv;
        end
        if (sz == 8 && !rx) begin
            if (e.dst >= 4) begin e.dst -= 4; e.dhi = 1; end
            if (!e.simm && e.src >= 4) begin e.src -= 4; e.shi = 1; end
        end
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        checks++;
        if (out_valid !== e.v || out_fault !== e.f || int'(out_size) != e.sz ||
            int'(out_dst) != e.dst || out_dst_hi !== e.dhi ||
            int'(out_src) != e.src || out_src_hi !== e.shi ||
            out_src_imm !== e.simm || out_imm !== e.imm || int'(out_len) != e.len) begin
            errors++;
            $display("FAIL %s actual v=%0b f=%0b sz=%0d d=%0d dh=%0b s=%0d sh=%0b si=%0b imm=%h len=%0d expected v=%0b f=%0b sz=%0d d=%0d dh=%0b s=%0d sh=%0b si=%0b imm=%h len=%0d",
                tag, out_valid, out_fault, out_size, out_dst, out_dst_hi, out_src,
                out_src_hi, out_src_imm, out_imm, out_len, e.v, e.f, e.sz, e.dst,
                e.dhi, e.src, e.shi, e.simm, e.imm, e.len);
        end
    endtask

    task automatic step(input string tag, input bit v);
        logic [NB*8-1:0] bb;
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        for (int i = 0; i < NB; i++) bb[i*8 +: 8] = 8'($urandom);
        for (int i = 0; i < sq.size() && i < NB; i++) bb[i*8 +: 8] = sq[i];
        in_valid = v;
        in_bytes = bb;
        exp_q.push_back(model(v, bb));
        tag_q.push_back(tag);
    endtask

    task automatic send(input string tag);
        step(tag, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops[12];
        ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                8'h80, 8'h81, 8'h83, 8'h0F, 8'h28, 8'h82};
        // R12: outputs held at zero in reset even with a valid ADD on the input
        in_valid = 1'b1;
        in_bytes = '0;
        in_bytes[15:0] = 16'hC801;
        repeat (3) @(negedge clk);
        compare('{0, 0, 0, 0, 0, 0, 0, 0, 64'd0, 0}, "R12");
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        sq = '{8'h01, 8'hC8};                 send("R1");
        sq = '{8'h01, 8'hC8};                 step("R1", 1'b0);
        sq = '{8'h66, 8'h01, 8'hC8};          send("R2");
        sq = '{8'h48, 8'h01, 8'hC8};          send("R2");
        sq = '{8'h66, 8'h48, 8'h01, 8'hC8};   send("R2");
        sq = '{8'h00, 8'hC8};                 send("R2");
        sq = '{8'h03, 8'hC8};                 send("R3");
        sq = '{8'h02, 8'hD1};                 send("R3");
        sq = '{8'h04, 8'h7F};                 send("R4");
        sq = '{8'h66, 8'h05, 8'h34, 8'h12};   send("R4");
        sq = '{8'h48, 8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF}; send("R4");
        sq = '{8'h80, 8'hC3, 8'h80};          send("R5");
        sq = '{8'h81, 8'hC3, 8'h78, 8'h56, 8'h34, 8'h12}; send("R5");
        sq = '{8'h81, 8'hCB, 8'h01, 8'h00, 8'h00, 8'h00}; send("R5");
        sq = '{8'h83, 8'hC3, 8'h80};          send("R5");
        sq = '{8'h48, 8'h83, 8'hC0, 8'hFF};   send("R6");
        sq = '{8'h66, 8'h83, 8'hC0, 8'h80};   send("R6");
        sq = '{8'h48, 8'h81, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h80}; send("R6");
        sq = '{8'h4D, 8'h01, 8'hC8};          send("R7");
        sq = '{8'h41, 8'h83, 8'hC7, 8'h05};   send("R7");
        sq = '{8'h00, 8'hE0};                 send("R8");
        sq = '{8'h40, 8'h00, 8'hE0};          send("R8");
        sq = '{8'h02, 8'hFC};                 send("R8");
        sq = '{8'h80, 8'hC5, 8'h01};          send("R8");
        sq = '{8'hF0, 8'h01, 8'hC8};          send("R9");
        sq = '{8'h66, 8'hF0, 8'h04, 8'h01};   send("R9");
        sq = '{8'h66, 8'h66, 8'h48, 8'h81, 8'hC0, 8'h11, 8'h22, 8'h33, 8'h44}; send("R10");
        sq = '{8'h66, 8'h81, 8'hC1, 8'h11, 8'h22}; send("R10");
        sq = '{8'h01, 8'h08};                 send("R11");
        sq = '{8'h0F, 8'hC8};                 send("R11");
        sq = '{8'hF0, 8'h01, 8'h08};          send("R11");
        sq = '{8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h01, 8'hC8}; send("R11");

        for (int n = 0; n < 3000; n++) begin
            int np;
            logic [7:0] op, m;
            sq.delete();
            np = $urandom_range(0, 2);
            for (int k = 0; k < np; k++)
                sq.push_back(($urandom_range(0, 7) == 0) ? 8'hF0 : 8'h66);
            if ($urandom_range(0, 1) == 1) sq.push_back(8'h40 | 8'($urandom_range(0, 15)));
            op = ops[$urandom_range(0, 11)];
            m = 8'($urandom);
            if ($urandom_range(0, 9) != 0) m[7:6] = 2'b11;
            if ($urandom_range(0, 4) != 0 && (op == 8'h80 || op == 8'h81 || op == 8'h83))
                m[5:3] = 3'd0;
            sq.push_back(op);
            sq.push_back(m);
            for (int k = 0; k < 4; k++) sq.push_back(8'($urandom));
            step("R1", $urandom_range(0, 9) != 0);
        end
        sq.delete();
        step("R1", 1'b0);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule